// File: doc/BRIEF.md
# Codec Control Register File with Indexed Window

This block is the control register file of an audio codec, seen by a host as a 64-byte memory-mapped region of sixteen 32-bit word slots. Behind one slot sits a second bank of thirty-two 8-bit registers. Software never addresses that bank directly. It writes an index into a pointer slot and then reads or writes through a data window slot.

Each location carries its own access rule. Some slots and indexed entries are read-only. One indexed entry is write-only and reads as zero. One indexed entry always carries a fixed version pattern, and only one bit of it can be written. A control slot stores a 7-bit value, and setting its lowest bit on a write returns the whole file to its reset state in that same cycle. Read data is combinational and is gated by the read strobe. Writes land on the rising clock edge while the write strobe is high.

Top module: `codec_ctl_regs`

## Requirements
- R1: After reset every word slot reads zero and every indexed entry reads zero, except indexed entry 12 (0x8A) and indexed entry 25 (0xA0).
- R2: The word slot is taken from byte-address bits [5:2], and bits [1:0] are ignored. Slots 0, 3 and 5 to 15 store and return all 32 written bits.
- R3: Bits [4:0] of slot 0 select the indexed entry. Slot 0 still keeps all 32 bits. Reads and writes at slot 1 reach the selected entry and use only write-data bits [7:0]. Reads return the entry zero-extended to 32 bits.
- R4: When the selected entry is 3, a read at slot 1 returns zero. A write to entry 3 is still accepted.
- R5: Writes to indexed entries 11 and 25 leave them unchanged.
- R6: A write to indexed entry 12 stores (write-data & 0x40) | 0x8A.
- R7: Writes to slot 2 are dropped, so slot 2 keeps reading zero.
- R8: A write to slot 4 stores write-data & 0x7F.
- R9: A write to slot 4 with bit 0 set returns every slot and every indexed entry to its R1 value in that cycle. Slot 4 then holds write-data & 0x7F.
- R10: While the read strobe is low, read data is zero.
- R11: While the write strobe is low, no stored value changes, whatever the address and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Byte address within the region |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| re_i | input | 1 | Read strobe, gates read data |
| rdata_o | output | 32 | Combinational read data |

## Verification
The assertions are checked on every cycle. They cover the fixed version bits of entries 12 and 25, the write-only read of entry 3, the 7-bit limit on slot 4, and read data being zero without a read strobe. They also check that entry 11 and slot 2 do not move on a write, that nothing moves without a write strobe, and that the soft reset clears state on the following cycle. Other behaviour needs a sequence of bus operations and only the bench's scenarios can show it. This includes pointer aliasing through the upper bits of slot 0, the byte offset being ignored, the masked data actually landing in entry 12, and the full set of values restored after a soft reset.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;
  localparam int DATA_W  = 32;
  localparam int IND_W   = 8;
  localparam int N_DIR   = 16;
  localparam int N_IND   = 32;
  localparam int ADDR_W  = 6;
  localparam int SLOT_W  = $clog2(N_DIR);
  localparam int PTR_W   = $clog2(N_IND);

  // word slots with special behaviour
  localparam int SLOT_PTR = 0;
  localparam int SLOT_WIN = 1;
  localparam int SLOT_RO  = 2;
  localparam int SLOT_CTL = 4;
  localparam logic [DATA_W-1:0] CTL_MASK = 32'h0000_007F;
  localparam int CTL_CLR_BIT = 0;

  // indexed entries with special behaviour
  localparam int IND_WO    = 3;
  localparam int IND_RO_A  = 11;
  localparam int IND_VER   = 12;
  localparam int IND_RO_B  = 25;
  localparam logic [IND_W-1:0] VER_CODEC = 8'h8A;
  localparam logic [IND_W-1:0] VER_CHIP  = 8'hA0;
  localparam logic [IND_W-1:0] VER_KEEP  = 8'h40;

  function automatic logic [IND_W-1:0] ind_rst_val(input int idx);
    if (idx == IND_VER)  return VER_CODEC;
    if (idx == IND_RO_B) return VER_CHIP;
    return '0;
  endfunction
endpackage

// File: rtl/codec_dir_regs.sv
module codec_dir_regs
  import codec_ctl_pkg::*;
#(
  parameter int N  = N_DIR,
  parameter int W  = DATA_W,
  parameter int SW = SLOT_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           soft_clr_i,
  input  logic           we_i,
  input  logic [SW-1:0]  slot_i,
  input  logic [W-1:0]   wdata_i,
  output logic [N*W-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [W-1:0] q;
    logic         hit;
    assign hit = we_i && (slot_i == SW'(g));
    assign q_o[g*W +: W] = q;

    if (g == SLOT_CTL) begin : g_ctl
      // store wins over the clear it triggers
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= '0;
        else if (hit)        q <= wdata_i & W'(CTL_MASK);
        else if (soft_clr_i) q <= '0;
      end
    end else if (g == SLOT_WIN || g == SLOT_RO) begin : g_fixed
      // not reachable by writes
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= '0;
        else if (soft_clr_i) q <= '0;
      end
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= '0;
        else if (soft_clr_i) q <= '0;
        else if (hit)        q <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/codec_ind_regs.sv
module codec_ind_regs
  import codec_ctl_pkg::*;
#(
  parameter int N  = N_IND,
  parameter int W  = IND_W,
  parameter int PW = PTR_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           soft_clr_i,
  input  logic           we_i,
  input  logic [PW-1:0]  ptr_i,
  input  logic [W-1:0]   wdata_i,
  output logic [N*W-1:0] q_o,
  output logic [W-1:0]   rd_o
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    localparam logic [W-1:0] RST = W'(ind_rst_val(g));
    logic [W-1:0] q;
    logic         hit;
    assign hit = we_i && (ptr_i == PW'(g));
    assign q_o[g*W +: W] = q;

    if (g == IND_RO_A || g == IND_RO_B) begin : g_ro
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= RST;
        else if (soft_clr_i) q <= RST;
      end
    end else if (g == IND_VER) begin : g_ver
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= RST;
        else if (soft_clr_i) q <= RST;
        else if (hit)        q <= (wdata_i & W'(VER_KEEP)) | W'(VER_CODEC);
      end
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= RST;
        else if (soft_clr_i) q <= RST;
        else if (hit)        q <= wdata_i;
      end
    end
  end

  // entry IND_WO is write-only
  assign rd_o = (ptr_i == PW'(IND_WO)) ? '0 : q_o[ptr_i*W +: W];
endmodule

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
  import codec_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [SLOT_W-1:0]       slot;
  logic [PTR_W-1:0]        ptr;
  logic                    soft_clr;
  logic                    ind_we;
  logic [N_DIR*DATA_W-1:0] dir_q;
  logic [N_IND*IND_W-1:0]  ind_q;
  logic [IND_W-1:0]        ind_rd;

  assign slot     = SLOT_W'(addr_i >> 2);
  assign ptr      = dir_q[SLOT_PTR*DATA_W +: PTR_W];
  assign soft_clr = we_i && (slot == SLOT_W'(SLOT_CTL)) && wdata_i[CTL_CLR_BIT];
  assign ind_we   = we_i && (slot == SLOT_W'(SLOT_WIN));

  codec_dir_regs #(.N(N_DIR), .W(DATA_W), .SW(SLOT_W)) u_dir (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_clr_i(soft_clr),
    .we_i      (we_i),
    .slot_i    (slot),
    .wdata_i   (wdata_i),
    .q_o       (dir_q)
  );

  codec_ind_regs #(.N(N_IND), .W(IND_W), .PW(PTR_W)) u_ind (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_clr_i(soft_clr),
    .we_i      (ind_we),
    .ptr_i     (ptr),
    .wdata_i   (wdata_i[IND_W-1:0]),
    .q_o       (ind_q),
    .rd_o      (ind_rd)
  );

  always_comb begin
    if (!re_i)                          rdata_o = '0;
    else if (slot == SLOT_W'(SLOT_WIN)) rdata_o = {{(DATA_W-IND_W){1'b0}}, ind_rd};
    else                                rdata_o = dir_q[slot*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/codec_ctl_regs_chk.sv
module codec_ctl_regs_chk
  import codec_ctl_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [DATA_W-1:0]       wdata_i,
  input logic                    we_i,
  input logic                    re_i,
  input logic [DATA_W-1:0]       rdata_o,
  input logic [N_DIR*DATA_W-1:0] dir_q_i,
  input logic [N_IND*IND_W-1:0]  ind_q_i
);
  logic [SLOT_W-1:0] c_slot;
  logic [PTR_W-1:0]  c_ptr;
  assign c_slot = SLOT_W'(addr_i >> 2);
  assign c_ptr  = dir_q_i[SLOT_PTR*DATA_W +: PTR_W];

  p_ver_chip_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ind_q_i[IND_RO_B*IND_W +: IND_W] == VER_CHIP);

  p_wo_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && c_slot == SLOT_W'(SLOT_WIN) && c_ptr == PTR_W'(IND_WO)) |-> rdata_o == '0);

  p_ro_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && c_slot == SLOT_W'(SLOT_WIN) && c_ptr == PTR_W'(IND_RO_A))
      |=> $stable(ind_q_i[IND_RO_A*IND_W +: IND_W]));

  p_ver_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ind_q_i[IND_VER*IND_W +: IND_W] & ~VER_KEEP) == VER_CODEC);

  p_ro_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && c_slot == SLOT_W'(SLOT_RO)) |=> $stable(dir_q_i[SLOT_RO*DATA_W +: DATA_W]));

  p_ctl_width_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q_i[SLOT_CTL*DATA_W +: DATA_W] & ~CTL_MASK) == '0);

  p_soft_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && c_slot == SLOT_W'(SLOT_CTL) && wdata_i[CTL_CLR_BIT])
      |=> (dir_q_i[SLOT_PTR*DATA_W +: DATA_W] == '0) && (ind_q_i[IND_W-1:0] == '0)
          && (dir_q_i[SLOT_CTL*DATA_W +: DATA_W] == ($past(wdata_i) & CTL_MASK)));

  p_rd_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> rdata_o == '0);

  p_no_we_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(dir_q_i) && $stable(ind_q_i)));
endmodule

bind codec_ctl_regs codec_ctl_regs_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .we_i   (we_i),
  .re_i   (re_i),
  .rdata_o(rdata_o),
  .dir_q_i(dir_q),
  .ind_q_i(ind_q)
);

// File: tb/codec_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module codec_ctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  codec_ctl_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata)
  );

  // behavioural reference
  int unsigned m_dir[16];
  int unsigned m_ind[32];

  function automatic void m_reset();
    foreach (m_dir[i]) m_dir[i] = 0;
    foreach (m_ind[i]) m_ind[i] = 0;
    m_ind[12] = 'h8A;
    m_ind[25] = 'hA0;
  endfunction

  function automatic int unsigned m_read(input int unsigned a);
    int unsigned s = (a >> 2) & 15;
    int unsigned ix = m_dir[0] & 31;
    if (s == 1) return (ix == 3) ? 0 : m_ind[ix];
    return m_dir[s];
  endfunction

  function automatic void m_write(input int unsigned a, input int unsigned d);
    int unsigned s = (a >> 2) & 15;
    int unsigned ix = m_dir[0] & 31;
    case (s)
      1: begin
        if (ix == 12) m_ind[ix] = (d & 'h40) | 'h8A;
        else if (ix != 11 && ix != 25) m_ind[ix] = d & 'hFF;
      end
      2: ;
      4: begin
        if (d[0]) m_reset();
        m_dir[4] = d & 'h7F;
      end
      default: m_dir[s] = d;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%0h actual=%08h expected=%08h", tag, addr, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, compare mid-cycle, model updates at edge
  task automatic cyc(input logic [5:0] a, input logic [31:0] d, input bit w, input bit r,
                     input string tag);
    @(negedge clk);
    addr = a; wdata = d; we = w; re = r;
    #2;
    check(tag, rdata, r ? m_read(a) : 32'h0);
    @(posedge clk);
    if (w) m_write(a, d);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input string tag);
    cyc(a, d, 1'b1, 1'b0, tag);
  endtask
  task automatic rd(input logic [5:0] a, input string tag);
    cyc(a, 32'h0, 1'b0, 1'b1, tag);
  endtask

  function automatic string ind_tag(input int i);
    if (i == 3) return "R4";
    if (i == 11 || i == 25) return "R5";
    if (i == 12) return "R6";
    return "R3";
  endfunction

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    re = 1'b1;
    #1;
    check("R1 in reset", rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    for (int s = 0; s < 16; s++) rd(6'(s * 4), "R1");
    for (int i = 0; i < 32; i++) begin
      wr(6'h00, 32'(i), "R1");
      rd(6'h04, "R1");
    end

    // R2: full-width slots, byte offset ignored
    for (int s = 0; s < 16; s++)
      if (s != 1 && s != 2 && s != 4) begin
        wr(6'(s * 4 + (s % 4)), 32'hA5000000 ^ (32'(s) * 32'h01010101), "R2");
        rd(6'(s * 4 + 3 - (s % 4)), "R2");
      end

    // R3: pointer aliasing, low byte only, zero-extension
    wr(6'h00, 32'hFFFF_FFE5, "R3");
    rd(6'h00, "R3");
    wr(6'h05, 32'hABCD_1234, "R3");
    rd(6'h04, "R3");
    rd(6'h14, "R3");

    // R3-R6 across all entries
    for (int i = 0; i < 32; i++) begin
      wr(6'h00, 32'(i), ind_tag(i));
      wr(6'h04, 32'hFFFF_FF00 | 32'((i * 37 + 17) & 8'hFF), ind_tag(i));
      rd(6'h04, ind_tag(i));
    end
    // R6: both values of the writable bit
    wr(6'h00, 32'd12, "R6");
    wr(6'h04, 32'hFF, "R6");
    rd(6'h04, "R6");
    wr(6'h04, 32'h00, "R6");
    rd(6'h04, "R6");
    // R4: write accepted though unreadable, visible via aliasing of no other path
    wr(6'h00, 32'd3, "R4");
    wr(6'h04, 32'h5A, "R4");
    rd(6'h04, "R4");

    // R7
    wr(6'h08, 32'hDEAD_BEEF, "R7");
    rd(6'h08, "R7");
    rd(6'h0B, "R7");

    // R8
    wr(6'h10, 32'hFFFF_FFFE, "R8");
    rd(6'h10, "R8");
    wr(6'h12, 32'h0000_0080, "R8");
    rd(6'h10, "R8");

    // R10
    cyc(6'h0C, 32'h0, 1'b0, 1'b0, "R10");
    cyc(6'h04, 32'h0, 1'b0, 1'b0, "R10");

    // R11: strobe low with live address/data
    wr(6'h00, 32'd7, "R11");
    cyc(6'h04, 32'h0000_0099, 1'b0, 1'b0, "R11");
    cyc(6'h10, 32'h0000_0001, 1'b0, 1'b0, "R11");
    cyc(6'h24, 32'h1234_5678, 1'b0, 1'b0, "R11");
    rd(6'h04, "R11");
    rd(6'h10, "R11");
    rd(6'h24, "R11");

    // R9: soft reset from a populated state
    wr(6'h00, 32'd12, "R9");
    wr(6'h04, 32'h40, "R9");
    wr(6'h10, 32'hFFFF_FF83, "R9");
    for (int s = 0; s < 16; s++) rd(6'(s * 4), "R9");
    for (int i = 0; i < 32; i++) begin
      wr(6'h00, 32'(i), "R9");
      rd(6'h04, "R9");
    end
    // R8: bit 0 clear does not reset
    wr(6'h0C, 32'h0000_1111, "R8");
    wr(6'h10, 32'h0000_007E, "R8");
    rd(6'h0C, "R8");
    rd(6'h10, "R8");

    cyc(6'h0, 32'h0, 1'b0, 1'b0, "R10");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule